// File: doc/BRIEF.md
# USB Device High-Speed Detection Controller

This block is the device-side state machine that negotiates high-speed operation while the bus is in reset. It receives the decoded line symbol and a squelch indication from the transceiver and drives four transceiver controls: the full-speed pull-up, the chirp-K current drive, the high-speed terminations and the high-speed mode flag. It also reports when it has put the device into suspend. Every duration is counted in pulses of a `tick` input, so a fast clock can measure microsecond-scale windows and a testbench can shrink the whole timebase.

A bus reset is recognised from a sustained SE0. The device answers by driving a chirp K for a fixed time and then listens for the hub's reply, which is a run of alternating K and J chirps. The reply counts only once enough ordered K-then-J pairs have each stayed stable for a debounce time. A lone J, such as the small offset the pull-up leaves on the line during SE0, never counts toward a pair. If no valid reply arrives before a timeout, the device stays at full speed. When a valid reply arrives, the device drops the pull-up, enables its terminations and raises the mode flag, all in the same cycle.

In high-speed mode an idle bus cannot at first be told apart from the start of a reset. After a long quiet period the device falls back to full-speed signalling and waits for the line to settle. It then samples the line: SE0 starts a new chirp, and any other symbol means suspend. From full-speed running or suspended states, SE0 is seen directly.

Top module: `usb_hs_detect`

## Requirements
- R1: While `rst_n` is low and after it rises, the block sits in full-speed running: `pullup_en`=1 and `chirp_k_en`, `hs_term_en`, `hs_mode`, `suspended` all 0. Line codes are 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1.
- R2: In full-speed running or suspended state, SE0 held stable for `T_RST_DET` ticks starts a chirp. During the chirp `chirp_k_en`=1, `pullup_en`=1 and `hs_term_en`=0. A shorter SE0 starts nothing.
- R3: The chirp drive stays on for `T_CHIRP` ticks and then turns off, and the block moves on to listening for the hub.
- R4: While listening, `N_PAIRS` ordered K-then-J pairs (each symbol stable `T_DEB` ticks with `squelch` low) switch the block to high speed. In the same cycle `pullup_en` goes to 0 and `hs_term_en` and `hs_mode` go to 1.
- R5: While listening, a J that is not preceded by a counted K is ignored, and symbols stable for fewer than `T_DEB` ticks are ignored. A stable SE0, or `squelch` high, clears the pair count.
- R6: If no valid pair sequence completes within `T_HUB_TMO` ticks of listening, the block returns to full-speed running with the pull-up on and `hs_mode`=0.
- R7: In full-speed running, J held for `T_SUSP` ticks sets `suspended`. While suspended, K held for `T_DEB` ticks clears it.
- R8: In high speed, `squelch` high (treated as SE0) for `T_HS_IDLE` ticks reverts the block to full-speed signalling (`pullup_en`=1, `hs_mode`=0, `hs_term_en`=0) for `T_SETTLE` ticks. The line is then sampled: SE0 starts a chirp, and any other symbol sets `suspended`.
- R9: In high speed, any cycle with `squelch` low and a non-SE0 symbol restarts the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase pulse; all durations count these |
| line_state | input | 2 | Decoded line symbol (SE0/J/K/SE1) |
| squelch | input | 1 | High when no valid high-speed signal is present |
| pullup_en | output | 1 | Full-speed pull-up enable |
| chirp_k_en | output | 1 | Chirp-K current drive enable |
| hs_term_en | output | 1 | High-speed termination enable |
| hs_mode | output | 1 | Device is operating at high speed |
| suspended | output | 1 | Device has entered suspend |

## Verification
The bench first sends a lone J before any K while the block listens. A design that accepted it would count a pair early and could enter high speed on too short a sequence. It then sends one-tick K/J glitches, and an SE0 gap after two good pairs. A design missing the debounce or the clearing on SE0 would switch to high speed without a complete run. It also breaks a high-speed idle period with one active cycle, which catches an idle counter that never restarts, and it ends one revert with SE0 and another with J, which catches a design that does not sample the line after settling. A listen phase with no reply shows whether the timeout really returns the block to full speed, because a J run then suspends it.

// File: rtl/hs_det_pkg.sv
// Shared types for the high-speed detection controller.
// Assumes the line decoder reports one of four symbols per cycle.
package hs_det_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    typedef enum logic [2:0] {
        ST_FS_RUN,
        ST_FS_SUSP,
        ST_CHIRP,
        ST_HUB_WAIT,
        ST_HS_RUN,
        ST_REVERT
    } hs_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hs_det_linefilt.sv
// Line stability tracker: registers the effective symbol, counts the ticks
// it has stayed unchanged (saturating), and pulses hit_q once in the cycle
// the count first reaches DEB. Assumes DEB >= 1 and DEB < 2**W.
module hs_det_linefilt
    import hs_det_pkg::*;
#(
    parameter int W   = 8,
    parameter int DEB = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  line_e        sym_i,
    output line_e        sym_q,
    output logic [W-1:0] run_q,
    output logic         hit_q
);

    localparam logic [W-1:0] RUN_SAT = '1;
    localparam logic [W-1:0] DEB_M1  = W'(DEB - 1);
    localparam logic [W-1:0] DEB_V   = W'(DEB);

    // Track symbol, its stable run length and the debounce hit pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q <= LS_J;
            run_q <= '0;
            hit_q <= 1'b0;
        end else begin
            sym_q <= sym_i;
            hit_q <= 1'b0;
            if (sym_i != sym_q) begin
                run_q <= '0;
            end else if (tick && run_q != RUN_SAT) begin
                run_q <= run_q + 1'b1;
                hit_q <= (run_q == DEB_M1);
            end
        end
    end

    // R5
    hit_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> (run_q == DEB_V));

endmodule

// File: rtl/hs_det_chirpseq.sv
// Hub chirp sequence counter: counts ordered K-then-J pairs from debounced
// symbol hits while enabled. A J without a preceding K is ignored; a stable
// SE0 clears the count. Everything clears while disabled.
module hs_det_chirpseq
    import hs_det_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          hit,
    input  line_e         sym,
    output logic [PW-1:0] pairs_q
);

    localparam logic [PW-1:0] PAIR_SAT = '1;

    logic want_j_q;

    // Advance the K/J pair count on each debounced symbol.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pairs_q  <= '0;
            want_j_q <= 1'b0;
        end else if (hit) begin
            unique case (sym)
                LS_K:   want_j_q <= 1'b1;
                LS_J: begin
                    if (want_j_q) begin
                        if (pairs_q != PAIR_SAT) pairs_q <= pairs_q + 1'b1;
                        want_j_q <= 1'b0;
                    end
                end
                LS_SE0: begin
                    pairs_q  <= '0;
                    want_j_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R5
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pairs_q != $past(pairs_q)) |->
            (pairs_q == '0 || pairs_q == $past(pairs_q) + 1'b1));

endmodule

// File: rtl/usb_hs_detect.sv
// Device-side high-speed detection controller. Detects bus reset from
// full-speed states or via a timed fallback from high-speed idle, sends a
// timed chirp K, counts hub K/J pairs and settles in high or full speed.
// Assumes tick is a single-cycle pulse and every duration is >= 1 tick.
module usb_hs_detect
    import hs_det_pkg::*;
#(
    parameter int T_RST_DET = 200,
    parameter int T_CHIRP   = 2000,
    parameter int T_HUB_TMO = 4000,
    parameter int T_SUSP    = 3000,
    parameter int T_HS_IDLE = 3050,
    parameter int T_SETTLE  = 500,
    parameter int T_DEB     = 3,
    parameter int N_PAIRS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] line_state,
    input  logic       squelch,
    output logic       pullup_en,
    output logic       chirp_k_en,
    output logic       hs_term_en,
    output logic       hs_mode,
    output logic       suspended
);

    localparam int T_MAX = imax(imax(imax(T_RST_DET, T_CHIRP), imax(T_HUB_TMO, T_SUSP)),
                                imax(imax(T_HS_IDLE, T_SETTLE), T_DEB));
    localparam int TW = $clog2(T_MAX + 2);
    localparam int PW = $clog2(N_PAIRS + 2);

    localparam logic [TW-1:0] C_RST    = TW'(T_RST_DET);
    localparam logic [TW-1:0] C_CHIRP  = TW'(T_CHIRP);
    localparam logic [TW-1:0] C_TMO    = TW'(T_HUB_TMO);
    localparam logic [TW-1:0] C_SUSP   = TW'(T_SUSP);
    localparam logic [TW-1:0] C_IDLE   = TW'(T_HS_IDLE);
    localparam logic [TW-1:0] C_SETTLE = TW'(T_SETTLE);
    localparam logic [TW-1:0] C_DEB    = TW'(T_DEB);
    localparam logic [TW-1:0] TMR_SAT  = '1;
    localparam logic [PW-1:0] C_PAIRS  = PW'(N_PAIRS);

    hs_state_e     state_q, state_d;
    logic [TW-1:0] tmr_q;
    line_e         sym_eff, sym_q;
    logic [TW-1:0] run_q;
    logic          hit_q;
    logic          seq_en;
    logic [PW-1:0] pairs_q;
    logic          squelch_masks;

    // Squelch reads as SE0 whenever high-speed receive is meaningful.
    always_comb begin
        squelch_masks = (state_q == ST_HS_RUN) || (state_q == ST_HUB_WAIT);
        sym_eff       = (squelch && squelch_masks) ? LS_SE0 : line_e'(line_state);
        seq_en        = (state_q == ST_HUB_WAIT);
    end

    hs_det_linefilt #(
        .W   (TW),
        .DEB (T_DEB)
    ) u_linefilt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .sym_i (sym_eff),
        .sym_q (sym_q),
        .run_q (run_q),
        .hit_q (hit_q)
    );

    hs_det_chirpseq #(
        .PW (PW)
    ) u_chirpseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (seq_en),
        .hit     (hit_q),
        .sym     (sym_q),
        .pairs_q (pairs_q)
    );

    // Next-state selection for the detection handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FS_RUN: begin
                if (sym_q == LS_SE0 && run_q >= C_RST)     state_d = ST_CHIRP;
                else if (sym_q == LS_J && run_q >= C_SUSP) state_d = ST_FS_SUSP;
            end
            ST_FS_SUSP: begin
                if (sym_q == LS_SE0 && run_q >= C_RST)    state_d = ST_CHIRP;
                else if (sym_q == LS_K && run_q >= C_DEB) state_d = ST_FS_RUN;
            end
            ST_CHIRP: begin
                if (tmr_q >= C_CHIRP) state_d = ST_HUB_WAIT;
            end
            ST_HUB_WAIT: begin
                if (pairs_q >= C_PAIRS)   state_d = ST_HS_RUN;
                else if (tmr_q >= C_TMO)  state_d = ST_FS_RUN;
            end
            ST_HS_RUN: begin
                if (sym_q == LS_SE0 && run_q >= C_IDLE) state_d = ST_REVERT;
            end
            ST_REVERT: begin
                if (tmr_q >= C_SETTLE)
                    state_d = (sym_q == LS_SE0) ? ST_CHIRP : ST_FS_SUSP;
            end
            default: state_d = ST_FS_RUN;
        endcase
    end

    // State register and per-state tick timer, cleared on every transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FS_RUN;
            tmr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q)             tmr_q <= '0;
            else if (tick && tmr_q != TMR_SAT)  tmr_q <= tmr_q + 1'b1;
        end
    end

    // Transceiver controls decoded from the current state.
    always_comb begin
        pullup_en  = (state_q != ST_HS_RUN);
        chirp_k_en = (state_q == ST_CHIRP);
        hs_term_en = (state_q == ST_HS_RUN);
        hs_mode    = (state_q == ST_HS_RUN);
        suspended  = (state_q == ST_FS_SUSP);
    end

    // R2
    chirp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chirp_k_en) |-> ($past(sym_q) == LS_SE0));

    // R2
    chirp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chirp_k_en |-> (pullup_en && !hs_term_en));

    // R3
    chirp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chirp_k_en) |-> ($past(tmr_q) >= C_CHIRP));

    // R4
    hs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> ($past(pairs_q) >= C_PAIRS));

    // R4
    hs_controls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_mode |-> (!pullup_en && hs_term_en && !chirp_k_en));

endmodule

// File: tb/usb_hs_detect_bench.sv
module usb_hs_detect_bench;

    localparam int P_RST = 4, P_CHIRP = 10, P_TMO = 60, P_SUSP = 12;
    localparam int P_IDLE = 15, P_SETTLE = 5, P_DEB = 2, P_PAIRS = 3;
    localparam logic [1:0] SE0 = 2'b00, LJ = 2'b01, LK = 2'b10;
    localparam int M_RUN = 0, M_SUSP = 1, M_CHIRP = 2, M_HUB = 3, M_HS = 4, M_REV = 5;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, squelch = 1'b1;
    logic [1:0] line_state = LJ;
    logic pullup_en, chirp_k_en, hs_term_en, hs_mode, suspended;
    int compared = 0, mismatched = 0;
    bit done = 1'b0;

    int m_st, m_ln, m_run, m_tmr, m_cnt;
    bit m_hit, m_exp;

    always #2.5 clk = ~clk;

    usb_hs_detect #(
        .T_RST_DET(P_RST), .T_CHIRP(P_CHIRP), .T_HUB_TMO(P_TMO), .T_SUSP(P_SUSP),
        .T_HS_IDLE(P_IDLE), .T_SETTLE(P_SETTLE), .T_DEB(P_DEB), .N_PAIRS(P_PAIRS)
    ) u_usb_hs_detect (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_state(line_state), .squelch(squelch),
        .pullup_en(pullup_en), .chirp_k_en(chirp_k_en), .hs_term_en(hs_term_en),
        .hs_mode(hs_mode), .suspended(suspended)
    );

    // Behavioural reference: symbol run lengths and phase timers as integers.
    always @(posedge clk) begin : ref_model
        int eff, nst;
        if (!rst_n) begin
            m_st = M_RUN; m_ln = 1; m_run = 0; m_tmr = 0; m_cnt = 0; m_hit = 0; m_exp = 0;
        end else begin
            eff = (squelch && (m_st == M_HS || m_st == M_HUB)) ? 0 : int'(line_state);
            nst = m_st;
            case (m_st)
                M_RUN:   if (m_ln == 0 && m_run >= P_RST) nst = M_CHIRP;
                         else if (m_ln == 1 && m_run >= P_SUSP) nst = M_SUSP;
                M_SUSP:  if (m_ln == 0 && m_run >= P_RST) nst = M_CHIRP;
                         else if (m_ln == 2 && m_run >= P_DEB) nst = M_RUN;
                M_CHIRP: if (m_tmr >= P_CHIRP) nst = M_HUB;
                M_HUB:   if (m_cnt >= P_PAIRS) nst = M_HS;
                         else if (m_tmr >= P_TMO) nst = M_RUN;
                M_HS:    if (m_ln == 0 && m_run >= P_IDLE) nst = M_REV;
                default: if (m_tmr >= P_SETTLE) nst = (m_ln == 0) ? M_CHIRP : M_SUSP;
            endcase
            if (m_st != M_HUB) begin
                m_cnt = 0; m_exp = 0;
            end else if (m_hit) begin
                if (m_ln == 2) m_exp = 1;
                else if (m_ln == 1 && m_exp) begin m_cnt++; m_exp = 0; end
                else if (m_ln == 0) begin m_cnt = 0; m_exp = 0; end
            end
            m_hit = (eff == m_ln) && tick && (m_run + 1 == P_DEB);
            if (eff != m_ln) m_run = 0;
            else if (tick) m_run++;
            m_ln = eff;
            if (nst != m_st) m_tmr = 0;
            else if (tick) m_tmr++;
            m_st = nst;
        end
    end

    function automatic string tag_of(input int st);
        case (st)
            M_RUN, M_SUSP: return "R7";
            M_CHIRP:       return "R3";
            M_HUB:         return "R5";
            M_HS:          return "R4";
            default:       return "R8";
        endcase
    endfunction

    // Compare every output against the reference on each clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [4:0] act, exp_v;
            act   = {pullup_en, chirp_k_en, hs_term_en, hs_mode, suspended};
            exp_v = {m_st != M_HS, m_st == M_CHIRP, m_st == M_HS, m_st == M_HS, m_st == M_SUSP};
            compared++;
            if (act !== exp_v) begin
                mismatched++;
                $display("FAIL %s cycle compare: actual %b expected %b", tag_of(m_st), act, exp_v);
            end
        end
    end

    task automatic chk_out(input string tag, input logic [4:0] exp_v);
        logic [4:0] act;
        act = {pullup_en, chirp_k_en, hs_term_en, hs_mode, suspended};
        compared++;
        if (act !== exp_v) begin
            mismatched++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp_v);
        end
    endtask

    task automatic hold(input logic [1:0] ln, input logic sq, input int nt);
        line_state = ln;
        squelch    = sq;
        repeat (nt * 2) @(negedge clk);
    endtask

    task automatic hub_pair(input int kt, input int jt);
        hold(LK, 1'b0, kt);
        hold(LJ, 1'b0, jt);
    endtask

    // {pullup, chirp, term, hs, susp}
    localparam logic [4:0] O_FS = 5'b10000, O_CHIRP = 5'b11000;
    localparam logic [4:0] O_HS = 5'b00110, O_SUSP = 5'b10001;

    initial begin : tick_gen
        forever begin
            @(negedge clk);
            tick = ~tick;
        end
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        chk_out("R1 in reset", O_FS);
        rst_n = 1'b1;
        @(negedge clk);
        chk_out("R1 after reset", O_FS);

        hold(LJ, 1'b1, 4);
        hold(SE0, 1'b1, 3);
        chk_out("R2 short SE0 ignored", O_FS);
        hold(SE0, 1'b1, 4);
        chk_out("R2 chirp from running", O_CHIRP);
        hold(SE0, 1'b1, 5);
        chk_out("R3 chirp still on", O_CHIRP);
        hold(SE0, 1'b1, 6);
        chk_out("R3 chirp ended", O_FS);
        hold(LJ, 1'b0, 5);
        chk_out("R5 lone J ignored", O_FS);
        hub_pair(3, 3);
        hub_pair(3, 3);
        hub_pair(3, 5);
        chk_out("R4 high speed entered", O_HS);

        hold(SE0, 1'b1, 10);
        chk_out("R9 short idle", O_HS);
        hold(LJ, 1'b0, 1);
        hold(SE0, 1'b1, 10);
        chk_out("R9 idle restarted", O_HS);
        hold(SE0, 1'b1, 8);
        chk_out("R8 reverted to full speed", O_FS);
        hold(SE0, 1'b1, 5);
        chk_out("R8 SE0 after settle chirps", O_CHIRP);
        hold(SE0, 1'b1, 10);
        hold(LK, 1'b0, 30);
        chk_out("R6 still listening", O_FS);
        hold(LK, 1'b0, 35);
        chk_out("R6 full speed after timeout", O_FS);
        hold(LJ, 1'b0, 15);
        chk_out("R6 R7 suspend after timeout", O_SUSP);
        hold(LK, 1'b0, 4);
        chk_out("R7 resume on K", O_FS);
        hold(LJ, 1'b0, 15);
        chk_out("R7 suspend again", O_SUSP);
        hold(SE0, 1'b1, 7);
        chk_out("R2 chirp from suspend", O_CHIRP);
        hold(SE0, 1'b1, 9);
        for (int i = 0; i < 4; i++) hub_pair(1, 1);
        chk_out("R5 glitches ignored", O_FS);
        hub_pair(3, 3);
        hub_pair(3, 3);
        hold(SE0, 1'b1, 4);
        hub_pair(3, 3);
        hub_pair(3, 4);
        chk_out("R5 SE0 cleared count", O_FS);
        hub_pair(3, 5);
        chk_out("R4 high speed after full run", O_HS);
        hold(SE0, 1'b1, 17);
        hold(LJ, 1'b0, 7);
        chk_out("R8 J after settle suspends", O_SUSP);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule